// File: doc/BRIEF.md
# Falling-Edge DMA Request Sequencer

This block runs one DMA channel in single-address mode. An external device asks for service by pulling an active-low request pin down. Each request it accepts becomes exactly one transfer. For each transfer the block asks for the system bus, waits for the grant, takes the bus for one activation state, and then drives an active-low acknowledge for a fixed single-transfer period.

Software arms the channel with one configuration write that carries a transfer count. The pin is sampled on every rising clock edge, starting at the edge after the one that completes the write. A low level seen while acceptance is open is latched as a pending request, and that latch is cleared when the transfer is activated. From then on, acceptance stays closed until the pin has been seen high again. This gives falling-edge behaviour without a separate edge detector: a pin that is simply held low produces only one transfer.

After the transfer that brings the count to zero, the bus is held for one extra dead state. The channel then disables itself and raises a done flag.

Top module: `dreq_edge_seq`

## Requirements
- R1: Out of reset the acknowledge is high, the bus request is low, the done flag is low and the channel is disabled.
- R2: A configuration write is taken only while the channel is disabled. The pin level at the clock edge that completes the write is ignored, and the first sample is taken at the following edge.
- R3: A low level sampled while acceptance is open is held as a pending request, and the bus request rises at the next edge.
- R4: Activation follows the edge at which the grant is sampled, and the acknowledge falls one edge later. At least two clock cycles separate the latch edge from the start of the acknowledge.
- R5: The acknowledge is low for exactly SGL_CYC cycles per transfer, and only while the bus request is high.
- R6: Activation clears the pending request. A high level sampled at any edge after activation, up to and including the edge that ends the acknowledge period, reopens acceptance right after that period.
- R7: If no high level has been seen by the end of the acknowledge period, acceptance stays closed until a high level is sampled. The next low level after that is accepted.
- R8: Each transfer decrements the count. On a transfer that does not reach zero, the bus request falls at the same edge at which the acknowledge rises.
- R9: On the transfer that reaches zero, the bus request stays high for one dead cycle after the acknowledge rises. At the end of that cycle the bus request falls, done rises and the channel disables, so later pin activity starts no transfer.
- R10: A configuration write with a count of zero raises done at the next edge and never requests the bus.
- R11: A configuration write while the channel is enabled has no effect on the count or on the enable.
- R12: An accepted configuration write with a nonzero count clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all sampling on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| req_n_i | input | 1 | Active-low transfer request pin |
| cfg_wr_i | input | 1 | Configuration write strobe: loads the count and enables the channel |
| cfg_cnt_i | input | CNT_W | Transfer count taken with the write |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| ack_n_o | output | 1 | Active-low acknowledge, low during the single-transfer period |
| done_o | output | 1 | Set when the count is exhausted; cleared by a nonzero write |

## Verification
The bench goes after the re-arm window. In one case the pin rises only at the edge that closes the acknowledge period. A design that sampled one edge too early would stall there, and the bench sees its bus request stay low. A pin held low across a whole transfer must not start a second one. A level-triggered design would start that second transfer, and the scoreboard would flag it as unexpected. Other cases cover the write-edge sample, a zero count, a write that arrives mid-run and a slow grant. A missing or misplaced dead cycle shows up as the bus request being released at the wrong edge or done rising at the wrong edge.

// File: rtl/dreq_seq_pkg.sv
package dreq_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_BREQ,
    ST_ACT,
    ST_SNGL,
    ST_DEAD
  } seq_st_e;
endpackage

// File: rtl/dreq_pin_arm.sv
module dreq_pin_arm (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic req_n_i,
  input  logic act_i,
  input  logic sgl_end_i,
  output logic pend_o
);
  logic pend_q;
  logic acc_q;
  logic hi_q;
  logic gate_q;
  logic see_hi;

  assign see_hi = hi_q | req_n_i;

  always_ff @(posedge clk) begin
    if (rst || !en_i) begin
      pend_q <= 1'b0;
      acc_q  <= 1'b1;
      hi_q   <= 1'b0;
      gate_q <= 1'b0;
    end else if (act_i) begin
      pend_q <= 1'b0;
      acc_q  <= 1'b0;
      hi_q   <= 1'b0;
      gate_q <= 1'b0;
    end else if (acc_q) begin
      if (!req_n_i) pend_q <= 1'b1;
    end else if (!pend_q) begin
      if (see_hi && (gate_q || sgl_end_i)) begin
        acc_q  <= 1'b1;
        hi_q   <= 1'b0;
        gate_q <= 1'b0;
      end else begin
        hi_q <= see_hi;
        if (sgl_end_i) gate_q <= 1'b1;
      end
    end
  end

  assign pend_o = pend_q;

  // R3: a held request survives until activation
  p_hold_until_act_r3: assert property (@(posedge clk) disable iff (rst)
    (pend_q && en_i && !act_i) |=> pend_q);

  // R6: activation removes the pending request
  p_clear_on_act_r6: assert property (@(posedge clk) disable iff (rst)
    (act_i && en_i) |=> !pend_q);

  // R7: acceptance reopens only after a high sample
  p_rearm_needs_high_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(acc_q) && $past(en_i)) |-> ($past(hi_q) || $past(req_n_i)));
endmodule

// File: rtl/dreq_xfer_cnt.sv
module dreq_xfer_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)         cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i)  cnt_q <= cnt_q - CNT_W'(1);
  end

  assign last_o = (cnt_q == CNT_W'(1));

  // R8: a transfer never runs with an empty count
  p_no_underflow_r8: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (cnt_q != '0));
endmodule

// File: rtl/dreq_seq_fsm.sv
module dreq_seq_fsm
  import dreq_seq_pkg::*;
#(
  parameter int SGL_CYC = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic en_i,
  input  logic pend_i,
  input  logic gnt_i,
  input  logic last_i,
  output logic act_o,
  output logic sgl_end_o,
  output logic dead_end_o,
  output logic breq_o,
  output logic ack_n_o
);
  localparam int SW = (SGL_CYC > 1) ? $clog2(SGL_CYC) : 1;

  seq_st_e       state_q, nxt;
  logic [SW-1:0] scnt_q;
  logic          breq_q, ack_q;
  logic          sgl_end;

  assign sgl_end = (state_q == ST_SNGL) && (scnt_q == SW'(SGL_CYC - 1));

  always_comb begin
    nxt = state_q;
    case (state_q)
      ST_IDLE: if (en_i && pend_i) nxt = ST_BREQ;
      ST_BREQ: if (gnt_i) nxt = ST_ACT;
      ST_ACT:  nxt = ST_SNGL;
      ST_SNGL: if (sgl_end) nxt = last_i ? ST_DEAD : ST_IDLE;
      ST_DEAD: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      scnt_q  <= '0;
      breq_q  <= 1'b0;
      ack_q   <= 1'b1;
    end else begin
      state_q <= nxt;
      scnt_q  <= (state_q == ST_SNGL && !sgl_end) ? scnt_q + SW'(1) : '0;
      breq_q  <= (nxt != ST_IDLE);
      ack_q   <= (nxt != ST_SNGL);
    end
  end

  assign act_o      = (state_q == ST_ACT);
  assign sgl_end_o  = sgl_end;
  assign dead_end_o = (state_q == ST_DEAD);
  assign breq_o     = breq_q;
  assign ack_n_o    = ack_q;

  // R4: activation only after a sampled grant
  p_act_after_grant_r4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACT) |-> $past(gnt_i));

  // R4: acknowledge starts right after activation
  p_ack_after_act_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(ack_n_o) |-> $past(state_q == ST_ACT));

  // R5: acknowledge only while holding the bus
  p_ack_has_bus_r5: assert property (@(posedge clk) disable iff (rst)
    !ack_n_o |-> breq_o);

  // R9: dead state lasts one cycle
  p_dead_one_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_DEAD) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/dreq_edge_seq.sv
module dreq_edge_seq #(
  parameter int CNT_W   = 8,
  parameter int SGL_CYC = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_n_i,
  input  logic             cfg_wr_i,
  input  logic [CNT_W-1:0] cfg_cnt_i,
  output logic             bus_req_o,
  input  logic             bus_gnt_i,
  output logic             ack_n_o,
  output logic             done_o
);
  logic en_q, done_q;
  logic wr_ok, cnt_zero;
  logic pend, act, sgl_end, dead_end, last;

  assign wr_ok    = cfg_wr_i && !en_q;
  assign cnt_zero = (cfg_cnt_i == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b0;
      done_q <= 1'b0;
    end else if (wr_ok) begin
      en_q   <= !cnt_zero;
      done_q <= cnt_zero;
    end else if (dead_end) begin
      en_q   <= 1'b0;
      done_q <= 1'b1;
    end
  end

  dreq_pin_arm u_arm (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_q),
    .req_n_i   (req_n_i),
    .act_i     (act),
    .sgl_end_i (sgl_end),
    .pend_o    (pend)
  );

  dreq_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst        (rst),
    .load_i     (wr_ok),
    .load_val_i (cfg_cnt_i),
    .dec_i      (sgl_end),
    .last_o     (last)
  );

  dreq_seq_fsm #(.SGL_CYC(SGL_CYC)) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .en_i       (en_q),
    .pend_i     (pend),
    .gnt_i      (bus_gnt_i),
    .last_i     (last),
    .act_o      (act),
    .sgl_end_o  (sgl_end),
    .dead_end_o (dead_end),
    .breq_o     (bus_req_o),
    .ack_n_o    (ack_n_o)
  );

  assign done_o = done_q;

  // R10: zero count finishes at once
  p_zero_load_r10: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_i && !en_q && cnt_zero) |=> (done_o && !en_q));

  // R9: finished channel holds no bus
  p_done_no_bus_r9: assert property (@(posedge clk) disable iff (rst)
    (done_q && !en_q) |-> !bus_req_o);

  // R11: a write while enabled leaves the enable in place
  p_wr_ignored_r11: assert property (@(posedge clk) disable iff (rst)
    (cfg_wr_i && en_q && !dead_end) |=> en_q);
endmodule

// File: tb/dreq_edge_seq_bench.sv
module dreq_edge_seq_bench;
  localparam int CNT_W = 8;
  localparam int SGL   = 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             req_n = 1'b1;
  logic             cfg_wr = 1'b0;
  logic [CNT_W-1:0] cfg_cnt = '0;
  logic             bus_gnt = 1'b0;
  logic             bus_req, ack_n, done;

  int checks = 0;
  int fails  = 0;
  int gdly   = 1;
  int gcnt   = 0;
  bit exp_q[$];

  always #10 clk = ~clk;

  dreq_edge_seq #(.CNT_W(CNT_W), .SGL_CYC(SGL)) u_dreq_edge_seq (
    .clk       (clk),
    .rst       (rst),
    .req_n_i   (req_n),
    .cfg_wr_i  (cfg_wr),
    .cfg_cnt_i (cfg_cnt),
    .bus_req_o (bus_req),
    .bus_gnt_i (bus_gnt),
    .ack_n_o   (ack_n),
    .done_o    (done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // arbiter model: grant after gdly cycles of request
  always @(negedge clk) begin
    if (bus_req) gcnt++;
    else gcnt = 0;
    bus_gnt = bus_req && (gcnt >= gdly);
  end

  // monitor: pops one expected item per finished acknowledge pulse
  logic prev_ack = 1'b1;
  int   run = 0;
  bit   post_chk = 1'b0;
  bit   post_last = 1'b0;
  always @(negedge clk) begin
    if (rst) begin
      prev_ack = 1'b1;
      run = 0;
      post_chk = 1'b0;
    end else begin
      if (post_chk) begin
        chk(done == post_last, "R9 done after transfer", done, post_last);
        chk(!bus_req, "R9 bus released after transfer", bus_req, 0);
        post_chk = 1'b0;
      end
      if (!ack_n) run++;
      else if (!prev_ack) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 unexpected transfer", 1, 0);
        end else begin
          bit e;
          e = exp_q.pop_front();
          chk(run == SGL, "R5 acknowledge length", run, SGL);
          if (e) chk(bus_req == 1'b1, "R9 dead cycle holds bus", bus_req, 1);
          else   chk(bus_req == 1'b0, "R8 bus dropped with acknowledge", bus_req, 0);
          post_chk  = 1'b1;
          post_last = e;
        end
        run = 0;
      end
      prev_ack = ack_n;
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) step();
    chk(ack_n == 1'b1, "R1 ack idle", ack_n, 1);
    chk(bus_req == 1'b0, "R1 bus idle", bus_req, 0);
    chk(done == 1'b0, "R1 done low", done, 0);
    rst = 1'b0;
    step();

    // R10: zero count
    cfg_wr = 1'b1; cfg_cnt = '0;
    step();
    cfg_wr = 1'b0;
    chk(done == 1'b1, "R10 done on zero load", done, 1);
    chk(bus_req == 1'b0, "R10 no bus on zero load", bus_req, 0);
    repeat (3) step();
    chk(bus_req == 1'b0, "R10 still no bus", bus_req, 0);

    // R2, R12: low only at the write edge is ignored
    cfg_wr = 1'b1; cfg_cnt = 8'd3; req_n = 1'b0;
    step();
    cfg_wr = 1'b0; req_n = 1'b1;
    chk(done == 1'b0, "R12 done cleared", done, 0);
    for (int i = 0; i < 6; i++) begin
      step();
      chk(bus_req == 1'b0, "R2 write-edge sample ignored", bus_req, 0);
    end

    // R3, R4: latch and timing
    exp_q.push_back(1'b0);
    req_n = 1'b0;
    step();
    req_n = 1'b1;
    chk(bus_req == 1'b0, "R3 no bus at latch edge", bus_req, 0);
    step();
    chk(bus_req == 1'b1, "R3 bus request after latch", bus_req, 1);
    step();
    chk(ack_n == 1'b1, "R4 activation state", ack_n, 1);
    step();
    chk(ack_n == 1'b0, "R4 acknowledge starts", ack_n, 0);
    repeat (4) step();

    // R6: high only at the closing edge still re-arms
    exp_q.push_back(1'b0);
    req_n = 1'b0;
    step();
    repeat (4) step();
    req_n = 1'b1;
    step();
    req_n = 1'b0;
    exp_q.push_back(1'b1);
    step();
    chk(bus_req == 1'b0, "R6 bus idle between transfers", bus_req, 0);
    step();
    chk(bus_req == 1'b1, "R6 re-armed at period end", bus_req, 1);
    req_n = 1'b1;
    repeat (10) step();
    chk(done == 1'b1, "R9 done after final", done, 1);
    req_n = 1'b0;
    repeat (2) step();
    req_n = 1'b1;
    repeat (6) step();
    chk(bus_req == 1'b0, "R9 pin ignored after done", bus_req, 0);
    chk(done == 1'b1, "R9 done holds", done, 1);

    // R7: held-low pin blocks acceptance
    cfg_wr = 1'b1; cfg_cnt = 8'd3;
    step();
    cfg_wr = 1'b0; req_n = 1'b0;
    exp_q.push_back(1'b0);
    step();
    repeat (6) step();
    for (int i = 0; i < 8; i++) begin
      step();
      chk(bus_req == 1'b0, "R7 blocked while low", bus_req, 0);
    end
    req_n = 1'b1;
    step();
    req_n = 1'b0;
    exp_q.push_back(1'b0);
    step();
    chk(bus_req == 1'b0, "R7 latch edge after high", bus_req, 0);
    step();
    chk(bus_req == 1'b1, "R7 accepted after high", bus_req, 1);
    req_n = 1'b1;
    repeat (8) step();

    // R11: write while enabled (one transfer left) has no effect
    cfg_wr = 1'b1; cfg_cnt = 8'd5;
    step();
    cfg_wr = 1'b0;
    exp_q.push_back(1'b1);
    req_n = 1'b0;
    step();
    req_n = 1'b1;
    repeat (10) step();
    chk(done == 1'b1, "R11 count not reloaded", done, 1);

    // R4: slow grant
    gdly = 4;
    cfg_wr = 1'b1; cfg_cnt = 8'd1;
    step();
    cfg_wr = 1'b0;
    exp_q.push_back(1'b1);
    req_n = 1'b0;
    step();
    req_n = 1'b1;
    step();
    chk(bus_req == 1'b1, "R3 bus request slow grant", bus_req, 1);
    repeat (4) step();
    chk(ack_n == 1'b1, "R4 waits for grant", ack_n, 1);
    step();
    chk(ack_n == 1'b0, "R4 acknowledge after grant", ack_n, 0);
    repeat (8) step();
    chk(done == 1'b1, "R9 done after slow grant", done, 1);

    chk(exp_q.size() == 0, "R8 missing transfers", exp_q.size(), 0);
    finish_run();
  end
endmodule